// File: doc/BRIEF.md
# Configurable Asynchronous Character Transmitter

This block turns one character at a time into a start/stop framed serial stream on a single logic-level output. A character is handed over with a valid/ready handshake. At that moment the block also captures three configuration inputs:

- the character length, 7 or 8 data bits;
- the parity mode, one of none, odd, even, always-one or always-zero;
- the length of the trailing stop period, 1, 1.5 or 2 bit times.

Bit timing comes from an enable pulse, `tick`, supplied by a rate generator outside the block at sixteen times the bit rate. Every bit lasts sixteen ticks. A one-and-a-half stop period therefore lasts exactly twenty-four ticks.

Between characters the output rests at logic 1. While a frame is on the line, `in_ready` is low and `busy` is high. Both return to their idle values on the first clock cycle after the final stop tick, so a waiting character leaves at the full line rate.

Top module: `async_char_tx`

## Requirements
- R1: After reset, and whenever no frame is in progress, `txd` is 1, `in_ready` is 1 and `busy` is 0.
- R2: A character is accepted on a rising clock edge where `in_valid` and `in_ready` are both 1. From the next cycle, `txd` is 0 (the start bit) for 16 ticks.
- R3: The data bits follow the start bit, least significant first, each lasting 16 ticks. When `cfg_len8`=1, 8 bits are sent. When `cfg_len8`=0, 7 bits are sent and `in_data[7]` never reaches the line.
- R4: `cfg_par` is coded as 0=none, 1=odd, 2=even, 3=always-one, 4=always-zero, and codes 5 to 7 act as none. With no parity, the stop period follows the last data bit directly. Otherwise one 16-tick parity bit sits between the last data bit and the stop period.
- R5: With odd parity, the parity bit makes the number of 1s over the sent data bits plus the parity bit odd. With even parity, it makes that number even.
- R6: Always-one parity sends 1 in the parity slot, and always-zero parity sends 0, whatever the data.
- R7: The stop period holds `txd` at 1 for 16, 24 or 32 ticks when `cfg_stop` is 0, 1 or 2 respectively, and code 3 acts as 2.
- R8: Data and configuration are sampled only at acceptance. Changes to `in_data`, `cfg_*` or `in_valid` while a frame is in progress have no effect on that frame.
- R9: `in_ready` is 0 and `busy` is 1 from the cycle after acceptance until the last stop tick. Both take their idle values on the very next cycle, so a new character can be accepted then.
- R10: While a frame is in progress, `txd` and `in_ready` change only on clock edges where `tick` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Enable pulse at 16 times the bit rate |
| in_data | input | 8 | Character to send |
| in_valid | input | 1 | Character offered |
| in_ready | output | 1 | Block can accept a character |
| cfg_len8 | input | 1 | 1 = 8 data bits, 0 = 7 data bits |
| cfg_par | input | 3 | Parity mode code (see R4) |
| cfg_stop | input | 2 | Stop period code (see R7) |
| txd | output | 1 | Serial line, idle high |
| busy | output | 1 | Frame in progress |

## Verification
A corrupted tick counter or bit index shows at the ports as a bit boundary that falls on the wrong tick. This is seen within one bit time, because the output is compared against its expected value after every tick of every frame. A parity or length register holding the wrong value shifts every later boundary or flips the parity slot, which shows before the frame ends. A wrong stop length moves the rise of `in_ready` away from its expected tick count. The bench checks this at the end of every frame, and the checker compares the total tick count at that rise against the shortest and longest legal frames.

// File: rtl/async_char_tx.sv
module async_char_tx #(
  parameter int OVERSAMPLE = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic [7:0] in_data,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic       cfg_len8,
  input  logic [2:0] cfg_par,
  input  logic [1:0] cfg_stop,
  output logic       txd,
  output logic       busy
);
  localparam int CW = $clog2(2 * OVERSAMPLE);
  localparam logic [CW-1:0] BIT_LAST  = CW'(OVERSAMPLE - 1);
  localparam logic [CW-1:0] HALF_LAST = CW'(OVERSAMPLE + OVERSAMPLE / 2 - 1);
  localparam logic [CW-1:0] TWO_LAST  = CW'(2 * OVERSAMPLE - 1);

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic [7:0]    sh;
  logic [2:0]    idx;
  logic          len8_q, pen_q, pbit_q;
  logic [1:0]    stop_q;
  logic [CW-1:0] stop_lim;
  logic          pen, pbit;

  wire [7:0] masked  = cfg_len8 ? in_data : {1'b0, in_data[6:0]};
  wire       odd_cnt = ^masked;
  wire       bit_end = tick && (cnt == BIT_LAST);
  wire [2:0] last_idx = len8_q ? 3'd7 : 3'd6;

  always_comb begin
    pen  = 1'b1;
    pbit = 1'b0;
    case (cfg_par)
      3'd1:    pbit = ~odd_cnt;
      3'd2:    pbit = odd_cnt;
      3'd3:    pbit = 1'b1;
      3'd4:    pbit = 1'b0;
      default: pen  = 1'b0;
    endcase
  end

  always_comb begin
    case (stop_q)
      2'd0:    stop_lim = BIT_LAST;
      2'd1:    stop_lim = HALF_LAST;
      default: stop_lim = TWO_LAST;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      cnt    <= '0;
      sh     <= '0;
      idx    <= '0;
      len8_q <= 1'b0;
      pen_q  <= 1'b0;
      pbit_q <= 1'b0;
      stop_q <= '0;
    end else begin
      case (st)
        S_IDLE: if (in_valid) begin
          sh     <= in_data;
          len8_q <= cfg_len8;
          pen_q  <= pen;
          pbit_q <= pbit;
          stop_q <= cfg_stop;
          cnt    <= '0;
          st     <= S_START;
        end
        S_START: if (tick) begin
          if (bit_end) begin
            cnt <= '0;
            idx <= '0;
            st  <= S_DATA;
          end else cnt <= cnt + 1'b1;
        end
        S_DATA: if (tick) begin
          if (bit_end) begin
            cnt <= '0;
            sh  <= sh >> 1;
            idx <= idx + 1'b1;
            if (idx == last_idx) st <= pen_q ? S_PAR : S_STOP;
          end else cnt <= cnt + 1'b1;
        end
        S_PAR: if (tick) begin
          if (bit_end) begin
            cnt <= '0;
            st  <= S_STOP;
          end else cnt <= cnt + 1'b1;
        end
        S_STOP: if (tick) begin
          if (cnt == stop_lim) begin
            cnt <= '0;
            st  <= S_IDLE;
          end else cnt <= cnt + 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign txd      = (st == S_START) ? 1'b0 :
                    (st == S_DATA)  ? sh[0] :
                    (st == S_PAR)   ? pbit_q : 1'b1;
  assign in_ready = (st == S_IDLE);
  assign busy     = (st != S_IDLE);
endmodule

// File: rtl/async_char_tx_chk.sv
module async_char_tx_chk #(
  parameter int OVERSAMPLE = 16
) (
  input logic clk,
  input logic rst_n,
  input logic tick,
  input logic in_valid,
  input logic in_ready,
  input logic txd,
  input logic busy
);
  localparam int MIN_T = OVERSAMPLE * 9;
  localparam int MAX_T = OVERSAMPLE * 12;

  logic [15:0] tc;
  always_ff @(posedge clk) begin
    if (!rst_n) tc <= '0;
    else if (in_valid && in_ready) tc <= '0;
    else if (tick && !in_ready) tc <= tc + 1'b1;
  end

  p_idle_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> (txd && !busy));

  p_start_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (!txd && !in_ready));

  p_stop_before_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_ready) |-> $past(txd));

  p_frame_len_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_ready) |-> (tc >= 16'(MIN_T) && tc <= 16'(MAX_T)));

  p_line_on_tick_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !in_ready) |=> ($stable(txd) && !in_ready));
endmodule

bind async_char_tx async_char_tx_chk #(.OVERSAMPLE(OVERSAMPLE)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .in_valid(in_valid),
  .in_ready(in_ready), .txd(txd), .busy(busy)
);

// File: tb/tb_async_char_tx.sv
module tb_async_char_tx;
  localparam int CLK_PERIOD = 10;
  localparam int OS = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic       cfg_len8 = 1'b1;
  logic [2:0] cfg_par = 3'd0;
  logic [1:0] cfg_stop = 2'd0;
  logic       txd;
  logic       busy;

  int total_chk = 0;
  int bad_chk = 0;
  int div_g = 1;
  int ph = 0;
  int cyc = 0;
  bit done = 1'b0;

  async_char_tx #(.OVERSAMPLE(OS)) dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .in_data(in_data),
    .in_valid(in_valid), .in_ready(in_ready), .cfg_len8(cfg_len8),
    .cfg_par(cfg_par), .cfg_stop(cfg_stop), .txd(txd), .busy(busy)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  always @(negedge clk) begin
    ph  = ph + 1;
    tick = ((ph % div_g) == 0);
  end

  always @(posedge clk) begin
    cyc = cyc + 1;
    if (cyc > 150000 && !done) begin
      done = 1'b1;
      total_chk++;
      bad_chk++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total_chk, bad_chk);
      $finish;
    end
  end

  function automatic bit par_bit(input logic [7:0] d, input bit l8, input int p);
    int ones = 0;
    for (int i = 0; i < (l8 ? 8 : 7); i++) ones += d[i];
    case (p)
      1: return (ones % 2 == 0);
      2: return (ones % 2 == 1);
      3: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic bit exp_bit(input int n, input logic [7:0] d, input bit l8, input int p);
    int b = n / OS;
    int l = l8 ? 8 : 7;
    bit pe = (p >= 1 && p <= 4);
    if (b == 0) return 1'b0;
    if (b <= l) return d[b-1];
    if (pe && b == l + 1) return par_bit(d, l8, p);
    return 1'b1;
  endfunction

  function automatic string region_tag(input int n, input bit l8, input int p);
    int b = n / OS;
    int l = l8 ? 8 : 7;
    bit pe = (p >= 1 && p <= 4);
    if (b == 0) return "R2";
    if (b <= l) return "R3";
    if (pe && b == l + 1) return (p == 1 || p == 2) ? "R5" : "R6";
    if (!pe && b == l + 1) return "R4";
    return "R7";
  endfunction

  task automatic run_frame(input logic [7:0] d, input bit l8, input int p, input int s,
                           input int div, input bit scramble);
    int l = l8 ? 8 : 7;
    int pe = (p >= 1 && p <= 4) ? 1 : 0;
    int stp = (s == 0) ? OS : (s == 1) ? (OS + OS / 2) : 2 * OS;
    int total = OS * (1 + l + pe) + stp;
    int n = 0;
    bit err = 1'b0;
    bit t;
    string msg;
    div_g = div;
    @(negedge clk);
    in_data  = d;
    cfg_len8 = l8;
    cfg_par  = 3'(p);
    cfg_stop = 2'(s);
    in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    if (scramble) begin
      in_data  = ~d;
      cfg_len8 = ~l8;
      cfg_par  = 3'((p + 2) % 5);
      cfg_stop = 2'((s + 1) % 3);
    end else in_valid = 1'b0;
    while (n < total) begin
      if (!err && (txd !== exp_bit(n, d, l8, p) || in_ready !== 1'b0 || busy !== 1'b1)) begin
        err = 1'b1;
        msg = (in_ready !== 1'b0 || busy !== 1'b1) ? "R9" : region_tag(n, l8, p);
        if (scramble) msg = {msg, "/R8"};
        $display("FAIL %s d=%h len8=%0d par=%0d stop=%0d tick#%0d: actual txd=%b rdy=%b busy=%b expected txd=%b rdy=0 busy=1",
                 msg, d, l8, p, s, n, txd, in_ready, busy, exp_bit(n, d, l8, p));
      end
      @(posedge clk);
      t = tick;
      @(negedge clk);
      if (t) n++;
    end
    in_valid = 1'b0;
    total_chk++;
    if (err) bad_chk++;
    total_chk++;
    if (in_ready !== 1'b1 || txd !== 1'b1 || busy !== 1'b0) begin
      bad_chk++;
      $display("FAIL R9/R1 end of frame d=%h: actual rdy=%b txd=%b busy=%b expected 1 1 0",
               d, in_ready, txd, busy);
    end
  endtask

  initial begin
    logic [7:0] pats [6] = '{8'h00, 8'hFF, 8'hA5, 8'h5A, 8'h80, 8'h01};
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    total_chk++;
    if (txd !== 1'b1 || in_ready !== 1'b1 || busy !== 1'b0) begin
      bad_chk++;
      $display("FAIL R1 reset: actual txd=%b rdy=%b busy=%b expected 1 1 0", txd, in_ready, busy);
    end
    for (int l = 0; l < 2; l++)
      for (int p = 0; p < 5; p++)
        for (int s = 0; s < 3; s++)
          for (int k = 0; k < 6; k++)
            run_frame(pats[k], l[0], p, s, 1, (k % 2) == 1);
    run_frame(8'h3C, 1'b1, 6, 3, 1, 1'b0);
    run_frame(8'hC3, 1'b0, 7, 3, 1, 1'b0);
    run_frame(8'h96, 1'b1, 1, 1, 3, 1'b0);
    run_frame(8'h69, 1'b0, 2, 2, 3, 1'b1);
    run_frame(8'h81, 1'b1, 3, 0, 2, 1'b1);
    run_frame(8'h7E, 1'b0, 4, 1, 2, 1'b0);
    repeat (5) @(negedge clk);
    total_chk++;
    if (txd !== 1'b1 || in_ready !== 1'b1) begin
      bad_chk++;
      $display("FAIL R1 idle after frames: actual txd=%b rdy=%b expected 1 1", txd, in_ready);
    end
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total_chk, bad_chk);
    $finish;
  end
endmodule